// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block decides, once per clock, whether a processor core should be asked to take a level interrupt, and which trap type it should take. It combines fifteen external level lines with the software-interrupt register. The two timer bits of that register do not stand for levels of their own; either one raises level 14. The block compares the merged pending set with the core's current interrupt level and picks the highest pending level above it. The result is a registered request flag and a registered trap-type index.

Three conditions keep a request from being raised. An outstanding vector interrupt freezes the resolver, because it outranks every level interrupt. Interrupts can be globally disabled. A nested request is held off when the trap being handled at the current trap level is a level interrupt of higher type than the new candidate. The core uses `irq_req` as its hard-interrupt line and `trap_idx` as the trap type to enter.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_req` and `trap_idx` become 0 at that edge.
- R2: Bits 1 to 15 of `soft_reg` count as pending levels 1 to 15, in the same way as the matching bits of `ext_lvl`.
- R3: Bit 0 (tick timer) and bit 16 (system timer) of `soft_reg` never count as levels of their own. Either of them set makes level 14 pending.
- R4: While `vec_busy` is high, `irq_req` and `trap_idx` keep their values at every edge, whatever the other inputs do.
- R5: If the merged pending vector, read as a number with level n at bit n, is below 2 << `cur_pil`, an active request is cleared at the next edge with `trap_idx` = 0, and no new request is raised.
- R6: With `int_en` high and no block in force, the highest pending level L above `cur_pil` is chosen. At the next edge `irq_req` = 1 and `trap_idx` = 0x40 | L, so levels 1 to 15 give types 0x41 to 0x4F.
- R7: If `trap_lvl` > 0, (`trap_type` & 0x1F0) = 0x40 and `trap_type` > 0x40 | L, no request is raised and both outputs hold. A `trap_type` equal to the candidate does not block it.
- R8: With `int_en` low, no request is raised, and an active request is cleared at the next edge with `trap_idx` = 0.
- R9: Nested hold-off needs both conditions: with `trap_lvl` = 0, or with a `trap_type` outside 0x40 to 0x4F, the candidate is raised normally.
- R10: While a request is active, a new higher pending level above `cur_pil` replaces `trap_idx` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 15 | External pending levels; bit n (1..15) is level n |
| soft_reg | input | 17 | Software-interrupt register; bits 1..15 are levels, bit 0 is the tick timer, bit 16 is the system timer |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| trap_type | input | 9 | Trap type held at the current trap level |
| vec_busy | input | 1 | Vector interrupt outstanding |
| irq_req | output | 1 | Hard-interrupt request (registered) |
| trap_idx | output | 9 | Selected trap type, 0 when idle (registered) |

## Verification
The hardest situation to reach from the ports is the nested hold-off. It only matters when a level trap is already in progress, so the bench sets `trap_lvl` and `trap_type` directly to mimic a core that sits inside a level-13 handler. It then presents candidates below, equal to and above that type. It also tries the near misses: trap level 0, and a trap type outside the level range. The vector-busy freeze is exercised in two ways. In the first, the pending set is changed while a request is active. In the second, the pending set is changed before any request exists, and the bench then confirms the request appears only after `vec_busy` falls.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
    localparam int LVL_N      = 16;
    localparam int SOFT_W     = 17;
    localparam int PIL_W      = 4;
    localparam int TT_W       = 9;
    localparam int TL_W       = 3;
    localparam int TICK_BIT   = 0;
    localparam int SYS_BIT    = 16;
    localparam int TIMER_LVL  = 14;
    localparam logic [TT_W-1:0] EXT_BASE  = 9'h040;
    localparam logic [TT_W-1:0] TT_GROUP  = 9'h1F0;

    typedef struct packed {
        logic            req;
        logic [TT_W-1:0] tt;
    } irq_state_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RAISE = 2'd1,
        ACT_DROP  = 2'd2
    } irq_act_e;

    function automatic logic [TT_W-1:0] make_tt(input logic [PIL_W-1:0] lvl);
        return EXT_BASE | TT_W'(lvl);
    endfunction
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
    parameter int LVL_N     = 16,
    parameter int SOFT_W    = 17,
    parameter int TICK_BIT  = 0,
    parameter int SYS_BIT   = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [LVL_N-1:1]  ext_lvl,
    input  logic [SOFT_W-1:0] soft_reg,
    output logic [LVL_N-1:0]  pend
);
    logic timer_hit;
    assign timer_hit = soft_reg[TICK_BIT] | soft_reg[SYS_BIT];

    assign pend[0] = 1'b0;
    for (genvar i = 1; i < LVL_N; i++) begin : g_lvl
        if (i == TIMER_LVL) begin : g_timer
            assign pend[i] = ext_lvl[i] | soft_reg[i] | timer_hit;
        end else begin : g_plain
            assign pend[i] = ext_lvl[i] | soft_reg[i];
        end
    end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
    parameter int LVL_N = 16,
    parameter int PIL_W = 4
) (
    input  logic [LVL_N-1:0] pend,
    input  logic [PIL_W-1:0] cur_pil,
    output logic             below,
    output logic [PIL_W-1:0] win_lvl
);
    localparam int THR_W = LVL_N + 1;
    logic [THR_W-1:0] thr;

    assign thr   = ({{(THR_W-1){1'b0}}, 1'b1} << cur_pil) << 1;
    assign below = {1'b0, pend} < thr;

    always_comb begin
        win_lvl = '0;
        for (int i = 1; i < LVL_N; i++) begin
            if (pend[i] && (PIL_W'(i) > cur_pil)) begin
                win_lvl = PIL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_nest_guard.sv
module irq_nest_guard
    import irqlvl_pkg::*;
#(
    parameter int TL_W = 3
) (
    input  logic [TL_W-1:0] trap_lvl,
    input  logic [TT_W-1:0] trap_type,
    input  logic [TT_W-1:0] cand_tt,
    output logic            hold_off
);
    logic in_level_range;
    assign in_level_range = (trap_type & TT_GROUP) == EXT_BASE;
    assign hold_off = (trap_lvl != '0) && in_level_range && (trap_type > cand_tt);
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irqlvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_N-1:1]  ext_lvl,
    input  logic [SOFT_W-1:0] soft_reg,
    input  logic [PIL_W-1:0]  cur_pil,
    input  logic              int_en,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [TT_W-1:0]   trap_type,
    input  logic              vec_busy,
    output logic              irq_req,
    output logic [TT_W-1:0]   trap_idx
);
    logic [LVL_N-1:0] pend;
    logic             below;
    logic [PIL_W-1:0] win_lvl;
    logic [TT_W-1:0]  cand_tt;
    logic             hold_off;
    irq_state_t       st_q, st_d;
    irq_act_e         act;

    irq_pend_merge #(
        .LVL_N(LVL_N), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
        .SYS_BIT(SYS_BIT), .TIMER_LVL(TIMER_LVL)
    ) u_merge (
        .ext_lvl(ext_lvl), .soft_reg(soft_reg), .pend(pend)
    );

    irq_level_pick #(.LVL_N(LVL_N), .PIL_W(PIL_W)) u_pick (
        .pend(pend), .cur_pil(cur_pil), .below(below), .win_lvl(win_lvl)
    );

    assign cand_tt = make_tt(win_lvl);

    irq_nest_guard #(.TL_W(TL_W)) u_guard (
        .trap_lvl(trap_lvl), .trap_type(trap_type),
        .cand_tt(cand_tt), .hold_off(hold_off)
    );

    always_comb begin
        act = ACT_HOLD;
        if (vec_busy) begin
            act = ACT_HOLD;
        end else if (below || !int_en) begin
            act = st_q.req ? ACT_DROP : ACT_HOLD;
        end else if (hold_off) begin
            act = ACT_HOLD;
        end else if (cand_tt != st_q.tt) begin
            act = ACT_RAISE;
        end
    end

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_RAISE: begin st_d.req = 1'b1; st_d.tt = cand_tt; end
            ACT_DROP:  begin st_d.req = 1'b0; st_d.tt = '0; end
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq_req  = st_q.req;
    assign trap_idx = st_q.tt;
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
    import irqlvl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            int_en,
    input logic            vec_busy,
    input logic            irq_req,
    input logic [TT_W-1:0] trap_idx
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq_req && trap_idx == '0));

    a_r4_busy_freezes: assert property (@(posedge clk) disable iff (rst)
        vec_busy |=> ($stable(irq_req) && $stable(trap_idx)));

    a_r6_type_in_range: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((trap_idx & TT_GROUP) == EXT_BASE && trap_idx[3:0] != 4'd0));

    a_r5_idle_index_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> trap_idx == '0);

    a_r8_disable_drops: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && !int_en && irq_req) |=> (!irq_req && trap_idx == '0));

    a_r8_no_raise_disabled: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && !int_en) |=> !$rose(irq_req));
endmodule

bind irq_level_resolver irq_level_resolver_chk u_chk (
    .clk(clk), .rst(rst), .int_en(int_en), .vec_busy(vec_busy),
    .irq_req(irq_req), .trap_idx(trap_idx)
);

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:1] ext_lvl;
    logic [16:0] soft_reg;
    logic [3:0]  cur_pil;
    logic        int_en;
    logic [2:0]  trap_lvl;
    logic [8:0]  trap_type;
    logic        vec_busy;
    logic        irq_req;
    logic [8:0]  trap_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_level_resolver u_dut (
        .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_reg(soft_reg),
        .cur_pil(cur_pil), .int_en(int_en), .trap_lvl(trap_lvl),
        .trap_type(trap_type), .vec_busy(vec_busy),
        .irq_req(irq_req), .trap_idx(trap_idx)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic er, input logic [8:0] et);
        checks++;
        if (irq_req !== er || trap_idx !== et) begin
            errors++;
            $display("FAIL %s: got req=%0b idx=%h expected req=%0b idx=%h",
                     req, irq_req, trap_idx, er, et);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ext_lvl = '0; soft_reg = '0; cur_pil = '0; int_en = 1'b1;
        trap_lvl = '0; trap_type = '0; vec_busy = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; ext_lvl = 15'h7FFF; soft_reg = '0; cur_pil = '0; int_en = 1'b1;
        trap_lvl = '0; trap_type = '0; vec_busy = 1'b0;
        tick();
        expect_out("R1 reset", 1'b0, 9'h000);
        rst = 1'b0; ext_lvl = '0;
    endtask

    task automatic t_ext_pick();
        do_reset();
        ext_lvl[3] = 1'b1; ext_lvl[9] = 1'b1;
        tick();
        expect_out("R6 highest external", 1'b1, 9'h049);
        ext_lvl[12] = 1'b1;
        tick();
        expect_out("R10 upgrade", 1'b1, 9'h04C);
    endtask

    task automatic t_soft();
        do_reset();
        soft_reg[5] = 1'b1;
        tick();
        expect_out("R2 soft level", 1'b1, 9'h045);
    endtask

    task automatic t_timer();
        do_reset();
        soft_reg[0] = 1'b1;
        tick();
        expect_out("R3 tick timer", 1'b1, 9'h04E);
        do_reset();
        soft_reg[16] = 1'b1;
        tick();
        expect_out("R3 system timer", 1'b1, 9'h04E);
        do_reset();
        soft_reg[0] = 1'b1; cur_pil = 4'd14;
        tick();
        expect_out("R3 timer masked at pil14", 1'b0, 9'h000);
    endtask

    task automatic t_mask();
        do_reset();
        cur_pil = 4'd9; ext_lvl[9] = 1'b1;
        tick();
        expect_out("R5 equal level masked", 1'b0, 9'h000);
        ext_lvl[12] = 1'b1;
        tick();
        expect_out("R6 above pil", 1'b1, 9'h04C);
        cur_pil = 4'd12;
        tick();
        expect_out("R5 withdraw", 1'b0, 9'h000);
    endtask

    task automatic t_busy();
        do_reset();
        soft_reg[5] = 1'b1;
        tick();
        vec_busy = 1'b1; soft_reg = '0; ext_lvl[11] = 1'b1;
        tick(); tick();
        expect_out("R4 busy holds active", 1'b1, 9'h045);
        do_reset();
        vec_busy = 1'b1; ext_lvl[7] = 1'b1;
        tick(); tick();
        expect_out("R4 busy blocks raise", 1'b0, 9'h000);
        vec_busy = 1'b0;
        tick();
        expect_out("R4 raise after busy", 1'b1, 9'h047);
    endtask

    task automatic t_disable();
        do_reset();
        int_en = 1'b0; ext_lvl[6] = 1'b1;
        tick(); tick();
        expect_out("R8 disabled no raise", 1'b0, 9'h000);
        int_en = 1'b1;
        tick();
        expect_out("R8 enable raises", 1'b1, 9'h046);
        int_en = 1'b0;
        tick();
        expect_out("R8 disable withdraws", 1'b0, 9'h000);
    endtask

    task automatic t_nested();
        do_reset();
        trap_lvl = 3'd1; trap_type = 9'h04D; ext_lvl[7] = 1'b1;
        tick(); tick();
        expect_out("R7 lower nested held", 1'b0, 9'h000);
        ext_lvl[15] = 1'b1;
        tick();
        expect_out("R7 higher nested raised", 1'b1, 9'h04F);
        do_reset();
        trap_lvl = 3'd2; trap_type = 9'h047; ext_lvl[7] = 1'b1;
        tick();
        expect_out("R7 equal type raised", 1'b1, 9'h047);
    endtask

    task automatic t_nested_near_miss();
        do_reset();
        trap_lvl = 3'd0; trap_type = 9'h04D; ext_lvl[7] = 1'b1;
        tick();
        expect_out("R9 trap level zero", 1'b1, 9'h047);
        do_reset();
        trap_lvl = 3'd1; trap_type = 9'h060; ext_lvl[7] = 1'b1;
        tick();
        expect_out("R9 type outside range", 1'b1, 9'h047);
    endtask

    initial begin
        t_reset();
        t_ext_pick();
        t_soft();
        t_timer();
        t_mask();
        t_busy();
        t_disable();
        t_nested();
        t_nested_near_miss();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule